// File: doc/BRIEF.md
# Synchronous Clock-Pair Stop Controller

This block gates a group of differential CPU clock pairs in response to an active-low stop request. The other pairs keep running. The internal CPU clock is a phase register that toggles on every edge of the system clock, so one CPU period is two system-clock cycles. The complement phase rises on alternate edges. A configuration write port loads a per-pair mask, and only the pairs marked in that mask react to the stop request.

The stop request is accepted only after it has been seen on two consecutive rising edges of the complement phase. Its release is qualified the same way. After acceptance, a fixed delay of `STOP_DLY` CPU periods passes. Each selected pair then parks on a complement rising edge. When parked, the true leg is held high, the complement leg is driven low, and the complement output-enable is dropped so the leg can float. On release, the pairs restart on a complement rising edge with a full low phase, so no shortened pulse appears. Each pair also drives a stopped status bit.

Mask writes are always captured. They are applied only when the controller is idle.

Top module: `clkstop_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every pair shows `pair_t`=0, `pair_c`=1, `pair_c_oe`=1, `pair_stopped`=0. The mask resets to all zeros, so no pair is stoppable.
- R2: A running pair toggles `pair_t` on every system-clock edge, and `pair_c` is always the inverse of `pair_t`. The complement rises on every second edge.
- R3: A stop is accepted only when `stop_n`=0 on two consecutive complement rising edges. A low level seen at only one such edge has no effect on any output.
- R4: A pair whose mask bit is 1 sets `pair_stopped` on the complement rising edge `STOP_DLY` edges after the accepting edge. With the default `STOP_DLY`=3, that is the 5th complement rise after `stop_n` goes low. `STOP_DLY` is limited to 2..6.
- R5: A parked pair holds `pair_t`=1, `pair_c`=0, `pair_c_oe`=0 and `pair_stopped`=1 for as long as it stays stopped.
- R6: A pair parks only after a high phase of `pair_t`: in the cycle before `pair_stopped` rises, `pair_t` is already 1.
- R7: A pair whose mask bit is 0 keeps toggling as in R2 while other pairs are stopped.
- R8: The release needs `stop_n`=1 on two consecutive complement rising edges. `pair_stopped` then clears `STOP_DLY` edges after the accepting edge, which is the 5th rise by default. The first released phase of `pair_t` is low for one cycle, and regular toggling follows.
- R9: A write on `cfg_we` captures `cfg_mask`, where bit i=1 makes pair i stoppable. The new mask is applied only when the controller is idle. Idle means no low sample of `stop_n` is held, no request is accepted or in flight, and no pair is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the CPU phase toggles on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Active-low stop request |
| cfg_we | input | 1 | Mask write strobe |
| cfg_mask | input | NPAIR | Mask write data; bit i=1 makes pair i stoppable |
| pair_t | output | NPAIR | True leg of each pair |
| pair_c | output | NPAIR | Complement leg of each pair |
| pair_c_oe | output | NPAIR | Complement-leg output enable (0 = floating) |
| pair_stopped | output | NPAIR | Per-pair stopped status |

## Verification
The bench counts complement rises on a pair that is never masked, and checks that parking and release each land on exactly the fifth rise. A design that skipped the two-sample qualification or the delay would report an early count. A design that parked at the wrong phase would show a low true leg just before `pair_stopped` rises. A single-edge low pulse on `stop_n` must leave every pair running; a one-sample filter would stop them. A mask written while pairs are parked must not release the parked pair or stop a new one until the next idle period, which catches a mask that is applied immediately.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        REQ_RUN  = 1'b0,
        REQ_STOP = 1'b1
    } req_state_e;

    typedef struct packed {
        logic t;
        logic c;
        logic oe;
        logic stopped;
    } pair_drive_t;

    // Drive values for a pair given whether it runs after this edge and the
    // current (pre-edge) CPU phase.
    function automatic pair_drive_t pair_drive(input logic run, input logic ph);
        pair_drive_t d;
        d.t       = run ? ~ph : 1'b1;
        d.c       = run ?  ph : 1'b0;
        d.oe      = run;
        d.stopped = ~run;
        return d;
    endfunction

    localparam pair_drive_t PAIR_RESET = '{t: 1'b0, c: 1'b1, oe: 1'b1, stopped: 1'b0};

endpackage

// File: rtl/clkstop_phase.sv
module clkstop_phase (
    input  logic clk,
    input  logic rst,
    output logic ph,
    output logic c_edge
);
    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    // The next edge moves ph 1->0, i.e. the complement phase rises.
    assign c_edge = ph;
endmodule

// File: rtl/clkstop_qual.sv
module clkstop_qual
    import clkstop_pkg::*;
#(
    parameter int STOP_DLY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic c_edge,
    input  logic stop_n,
    output logic req_dly,
    output logic busy
);
    localparam int SH = STOP_DLY - 1;

    logic       samp0;
    req_state_e state;
    logic [SH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp0 <= 1'b1;
            state <= REQ_RUN;
        end else if (c_edge) begin
            samp0 <= stop_n;
            if (!samp0 && !stop_n)     state <= REQ_STOP;
            else if (samp0 && stop_n)  state <= REQ_RUN;
        end
    end

    generate
        if (SH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)         chain <= '0;
                else if (c_edge) chain[0] <= (state == REQ_STOP);
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)         chain <= '0;
                else if (c_edge) chain <= {chain[SH-2:0], (state == REQ_STOP)};
            end
        end
    endgenerate

    assign req_dly = chain[SH-1];
    assign busy    = ~samp0 | (state == REQ_STOP) | (|chain);

    initial begin
        assert (STOP_DLY >= 2 && STOP_DLY <= 6)
            else $error("STOP_DLY out of range");
    end

    // R3: acceptance needs a low sample now and at the previous complement rise
    assert_two_sample_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (state == REQ_STOP && $past(state) == REQ_RUN) |->
            ($past(c_edge) && !$past(stop_n) && !$past(samp0)));

    // R8: release needs two high samples
    assert_two_sample_release_R8: assert property (@(posedge clk) disable iff (rst)
        (state == REQ_RUN && $past(state) == REQ_STOP) |->
            ($past(c_edge) && $past(stop_n) && $past(samp0)));
endmodule

// File: rtl/clkstop_mask.sv
module clkstop_mask #(
    parameter int NPAIR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [NPAIR-1:0] cfg_mask,
    input  logic             idle,
    output logic [NPAIR-1:0] active
);
    logic [NPAIR-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (cfg_we) shadow <= cfg_mask;
            if (idle)   active <= shadow;
        end
    end

    // R9: the applied mask never moves while a stop is pending or held
    assert_mask_only_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> $past(idle));
endmodule

// File: rtl/clkstop_pair.sv
module clkstop_pair
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph,
    input  logic c_edge,
    input  logic mask_bit,
    input  logic req_dly,
    output logic out_t,
    output logic out_c,
    output logic out_oe,
    output logic out_stopped
);
    pair_drive_t drv;
    logic        want_stop;
    logic        run_nx;

    always_comb begin
        want_stop = mask_bit & req_dly;
        run_nx    = c_edge ? ~want_stop : ~drv.stopped;
    end

    always_ff @(posedge clk) begin
        if (rst) drv <= PAIR_RESET;
        else     drv <= pair_drive(run_nx, ph);
    end

    assign out_t       = drv.t;
    assign out_c       = drv.c;
    assign out_oe      = drv.oe;
    assign out_stopped = drv.stopped;

    // R5: parked level
    assert_park_level_R5: assert property (@(posedge clk) disable iff (rst)
        out_stopped |-> (out_t && !out_c && !out_oe));

    // R6: park only after a high phase
    assert_no_runt_R6: assert property (@(posedge clk) disable iff (rst)
        (out_stopped && !$past(out_stopped)) |-> ($past(out_t) && $past(c_edge)));

    // R7: an unselected running pair keeps toggling
    assert_unmasked_runs_R7: assert property (@(posedge clk) disable iff (rst)
        (!mask_bit && !out_stopped) |=> (out_t != $past(out_t)));

    // R2: legs are complementary while running
    assert_complementary_R2: assert property (@(posedge clk) disable iff (rst)
        !out_stopped |-> (out_c == !out_t));
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top #(
    parameter int NPAIR    = 4,
    parameter int STOP_DLY = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_n,
    input  logic             cfg_we,
    input  logic [NPAIR-1:0] cfg_mask,
    output logic [NPAIR-1:0] pair_t,
    output logic [NPAIR-1:0] pair_c,
    output logic [NPAIR-1:0] pair_c_oe,
    output logic [NPAIR-1:0] pair_stopped
);
    logic             ph;
    logic             c_edge;
    logic             req_dly;
    logic             busy;
    logic [NPAIR-1:0] active;
    logic             idle;

    clkstop_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .ph     (ph),
        .c_edge (c_edge)
    );

    clkstop_qual #(.STOP_DLY(STOP_DLY)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .c_edge  (c_edge),
        .stop_n  (stop_n),
        .req_dly (req_dly),
        .busy    (busy)
    );

    assign idle = ~busy & ~(|pair_stopped);

    clkstop_mask #(.NPAIR(NPAIR)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mask (cfg_mask),
        .idle     (idle),
        .active   (active)
    );

    generate
        for (genvar i = 0; i < NPAIR; i++) begin : g_pair
            clkstop_pair u_pair (
                .clk         (clk),
                .rst         (rst),
                .ph          (ph),
                .c_edge      (c_edge),
                .mask_bit    (active[i]),
                .req_dly     (req_dly),
                .out_t       (pair_t[i]),
                .out_c       (pair_c[i]),
                .out_oe      (pair_c_oe[i]),
                .out_stopped (pair_stopped[i])
            );
        end
    endgenerate

    // R4: stopping happens only on complement rising edges
    assert_stop_on_cedge_R4: assert property (@(posedge clk) disable iff (rst)
        (pair_stopped != $past(pair_stopped)) |-> $past(c_edge));
endmodule

// File: tb/clkstop_top_bench.sv
module clkstop_top_bench;
    localparam int N   = 4;
    localparam int DLY = 3;
    localparam int EXP_RISES = 2 + DLY;
    localparam int REF = N - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stop_n = 1'b1;
    logic         cfg_we = 1'b0;
    logic [N-1:0] cfg_mask = '0;
    logic [N-1:0] pair_t, pair_c, pair_c_oe, pair_stopped;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic pre_t0;
    logic pre_t2;

    always #4 clk = ~clk;

    clkstop_top #(.NPAIR(N), .STOP_DLY(DLY)) u_clkstop_top (
        .clk(clk), .rst(rst), .stop_n(stop_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
        .pair_t(pair_t), .pair_c(pair_c), .pair_c_oe(pair_c_oe), .pair_stopped(pair_stopped)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a rise of the reference complement leg; record pair_t before it.
    task automatic wait_crise();
        logic prev;
        for (int k = 0; k < 50; k++) begin
            prev   = pair_c[REF];
            pre_t0 = pair_t[0];
            pre_t2 = pair_t[2];
            @(negedge clk);
            if (!prev && pair_c[REF]) return;
        end
        chk(0, "ref clock rise", 0, 1);
    endtask

    task automatic write_mask(input logic [N-1:0] m);
        cfg_mask = m;
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Drive stop_n and count reference rises until pair idx reaches target stopped value
    task automatic count_to(input int idx, input logic target, input string req);
        int n = 0;
        logic pre;
        for (int k = 1; k <= 12; k++) begin
            wait_crise();
            n = k;
            if (pair_stopped[idx] == target) break;
        end
        pre = (idx == 0) ? pre_t0 : pre_t2;
        chk(n == EXP_RISES, req, n, EXP_RISES);
        if (target) chk(pre == 1'b1, "R6 true high before park", pre, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pair_t == '0,       "R1 t", pair_t, 0);
        chk(pair_c == '1,       "R1 c", pair_c, 15);
        chk(pair_c_oe == '1,    "R1 oe", pair_c_oe, 15);
        chk(pair_stopped == '0, "R1 stopped", pair_stopped, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pair_stopped == '0 && pair_c_oe == '1, "R1 after release", pair_stopped, 0);
    endtask

    task automatic t_running();
        logic [N-1:0] prev;
        int rises = 0;
        prev = pair_t;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(pair_t == ~prev, "R2 toggle", pair_t, ~prev);
            chk(pair_c == ~pair_t, "R2 complement", pair_c, ~pair_t);
            if (prev[REF] && !pair_t[REF]) rises++;
            prev = pair_t;
        end
        chk(rises == 4, "R2 complement rises every second edge", rises, 4);
    endtask

    task automatic t_glitch();
        write_mask(4'b0011);
        repeat (4) @(negedge clk);
        wait_crise();
        stop_n = 1'b0;
        wait_crise();
        stop_n = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (pair_stopped != '0) begin
                chk(0, "R3 single low sample ignored", pair_stopped, 0);
                break;
            end
        end
        chk(pair_stopped == '0 && pair_c_oe == '1, "R3 still running", pair_stopped, 0);
    endtask

    task automatic t_stop_release();
        logic [N-1:0] prev;
        stop_n = 1'b0;
        count_to(0, 1'b1, "R4 stop latency");
        chk(pair_stopped == 4'b0011, "R4 selected pairs stopped", pair_stopped, 3);
        prev = pair_t;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(pair_t[1:0] == 2'b11 && pair_c[1:0] == 2'b00 && pair_c_oe[1:0] == 2'b00,
                "R5 parked", {pair_t[1:0], pair_c[1:0]}, 12);
            chk(pair_t[3:2] == ~prev[3:2], "R7 unmasked toggles", pair_t[3:2], ~prev[3:2]);
            prev = pair_t;
        end
        stop_n = 1'b1;
        count_to(0, 1'b0, "R8 release latency");
        chk(pair_t[0] == 1'b0 && pair_c_oe[0], "R8 first phase low", pair_t[0], 0);
        @(negedge clk);
        chk(pair_t[0] == 1'b1, "R8 then high", pair_t[0], 1);
        @(negedge clk);
        chk(pair_t[0] == 1'b0, "R8 regular toggle", pair_t[0], 0);
    endtask

    task automatic t_mask_defer();
        stop_n = 1'b0;
        count_to(0, 1'b1, "R4 stop latency again");
        write_mask(4'b0100);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(pair_stopped == 4'b0011, "R9 mask held while stopped", pair_stopped, 3);
        end
        stop_n = 1'b1;
        count_to(0, 1'b0, "R8 release before new mask");
        repeat (6) @(negedge clk);
        stop_n = 1'b0;
        count_to(2, 1'b1, "R9 new mask stop latency");
        chk(pair_stopped == 4'b0100, "R9 new mask applied", pair_stopped, 4);
        stop_n = 1'b1;
        count_to(2, 1'b0, "R8 final release");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_running();
        t_glitch();
        t_stop_release();
        t_mask_defer();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule